// File: doc/BRIEF.md
# Bounded Range Wraparound Counter

This block counts through a fixed, contiguous window of values, from a low bound up to a high bound, and then returns to the low bound. The counting element is a small synchronous counter that can be cleared or loaded on a clock edge. The window is formed by decoding the counter's own output and feeding that decode back into the clear or load control. No separate compare register is used.

Both bounds are elaboration-time parameters, and the feedback path is chosen from them. A low bound of zero uses the synchronous clear. A high bound equal to the all-ones code uses the counter's carry as the wrap detect. Any other range decodes the high bound and drives a load of the low bound.

The block is typically used as a modulo-N divider or as a timing state sequencer. A terminal pulse marks the last step of each pass through the window.

Top module: `range_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `count` takes the value START on that edge.
- R2: With `en` high and `count` below STOP, `count` increases by exactly one on each rising edge.
- R3: With `en` high and `count` equal to STOP, the next edge returns `count` to START, so STOP is visible for one full cycle.
- R4: With `en` low, `count` holds its value on the edge, including when it equals STOP (no wrap occurs).
- R5: `tc` is high exactly when `count` equals STOP and `en` is high.
- R6: When START is 0, wrapping is done by the synchronous clear, giving 0..STOP (e.g. 0..9 and 0..11).
- R7: When STOP is the all-ones code (15 for WIDTH 4), the carry condition triggers the wrap, e.g. 7..15 and 10..15.
- R8: After reset, `count` never leaves the range START..STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset to START |
| en | input | 1 | Count enable |
| count | output | WIDTH | Current counter value |
| tc | output | 1 | Terminal pulse, high on the last enabled step of the window |

## Verification
Five instances run in parallel, covering the ranges 4..9, 0..9, 0..11, 7..15 and 10..15. This exercises the load, clear and carry wrap paths side by side.

The bench drops the enable while the count sits on the high bound. A design that wrapped without enable would jump to START there and lose the hold.

A design that wrapped one edge early would never show STOP as a value. A design that compared against the wrong bound would step past STOP or land outside the range.

Reset is applied in the middle of a pass. This catches a design that resets to zero instead of to START when the low bound is nonzero.

// File: rtl/range_counter.sv
module range_counter #(
  parameter int WIDTH = 4,
  parameter int START = 4,
  parameter int STOP  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [WIDTH-1:0] count,
  output logic             tc
);
  localparam logic [WIDTH-1:0] LO  = WIDTH'(START);
  localparam logic [WIDTH-1:0] HI  = WIDTH'(STOP);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
  localparam bit TOP_IS_MAX = (STOP == (2**WIDTH) - 1);
  localparam bit LOW_IS_ZERO = (START == 0);

  logic [WIDTH-1:0] q;
  logic             hit;
  logic             clr_n;
  logic             ld_n;

  generate
    if (TOP_IS_MAX) begin : g_carry
      assign hit = en & (&q);
    end else begin : g_decode
      assign hit = en & (q == HI);
    end

    if (LOW_IS_ZERO) begin : g_clear
      assign clr_n = rst_n & ~hit;
      assign ld_n  = 1'b1;
    end else begin : g_load
      assign clr_n = 1'b1;
      assign ld_n  = rst_n & ~hit;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!clr_n)      q <= '0;
    else if (!ld_n)  q <= LO;
    else if (en)     q <= q + ONE;
  end

  assign count = q;
  assign tc    = hit;

  logic started = 1'b0;
  always_ff @(posedge clk) if (!rst_n) started <= 1'b1;

  AST_RESET_TO_START: assert property (@(posedge clk) !rst_n |=> count == LO); // R1
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    started && en && count != HI |=> count == $past(count) + ONE); // R2
  AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
    started && en && count == HI |=> count == LO); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    started && !en |=> $stable(count)); // R4
  AST_TC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> tc == (en && count == HI)); // R5
  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (count >= LO && count <= HI)); // R8
endmodule

// File: tb/tb_range_counter.sv
`timescale 1ns/1ps
module tb_range_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0] c [5];
  logic       t [5];

  localparam int LO [5] = '{4, 0, 0, 7, 10};
  localparam int HI [5] = '{9, 9, 11, 15, 15};

  range_counter #(.WIDTH(4), .START(4),  .STOP(9))  dut     (.clk(clk), .rst_n(rst_n), .en(en), .count(c[0]), .tc(t[0]));
  range_counter #(.WIDTH(4), .START(0),  .STOP(9))  u_dec   (.clk(clk), .rst_n(rst_n), .en(en), .count(c[1]), .tc(t[1]));
  range_counter #(.WIDTH(4), .START(0),  .STOP(11)) u_twelve(.clk(clk), .rst_n(rst_n), .en(en), .count(c[2]), .tc(t[2]));
  range_counter #(.WIDTH(4), .START(7),  .STOP(15)) u_seven (.clk(clk), .rst_n(rst_n), .en(en), .count(c[3]), .tc(t[3]));
  range_counter #(.WIDTH(4), .START(10), .STOP(15)) u_ten   (.clk(clk), .rst_n(rst_n), .en(en), .count(c[4]), .tc(t[4]));

  int runs = 0;
  int fails = 0;
  int exp_v [5];
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int idx, input int act, input int expv);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s unit%0d actual=%0d expected=%0d", req, idx, act, expv);
    end
  endtask

  task automatic step(input logic r, input logic e);
    string tag [5];
    rst_n = r;
    en = e;
    #1;
    for (int i = 0; i < 5; i++) begin
      if (r) check(t[i] == (e && exp_v[i] == HI[i]), "R5", i, int'(t[i]), int'(e && exp_v[i] == HI[i]));
    end
    @(posedge clk);
    for (int i = 0; i < 5; i++) begin
      if (!r) begin tag[i] = "R1"; exp_v[i] = LO[i]; end
      else if (!e) tag[i] = "R4";
      else if (exp_v[i] == HI[i]) begin
        tag[i] = (i == 1 || i == 2) ? "R6" : (i >= 3) ? "R7" : "R3";
        exp_v[i] = LO[i];
      end else begin tag[i] = "R2"; exp_v[i] = exp_v[i] + 1; end
    end
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      check(int'(c[i]) == exp_v[i], tag[i], i, int'(c[i]), exp_v[i]);
      check(int'(c[i]) >= LO[i] && int'(c[i]) <= HI[i], "R8", i, int'(c[i]), LO[i]);
    end
  endtask

  task automatic t_reset();
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
  endtask

  task automatic t_full_passes();
    repeat (40) step(1'b1, 1'b1);
  endtask

  task automatic t_hold_at_stop();
    repeat (3) step(1'b1, 1'b0);
    while (exp_v[0] != HI[0]) step(1'b1, 1'b1);
    repeat (3) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    while (exp_v[3] != HI[3]) step(1'b1, 1'b1);
    repeat (2) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
  endtask

  task automatic t_gapped_enable();
    for (int k = 0; k < 45; k++) step(1'b1, (k % 3) != 1);
  endtask

  task automatic t_mid_reset();
    repeat (5) step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    repeat (14) step(1'b1, 1'b1);
  endtask

  initial begin
    t_reset();
    t_full_passes();
    t_hold_at_stop();
    t_gapped_enable();
    t_mid_reset();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      runs++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule